// File: doc/BRIEF.md
# Floating-Point Sign Manipulation Unit

This unit performs the three bit-level sign operations on a 64-bit floating-point register value: magnitude (clear the sign), flip (invert the sign) and sign transfer (take the sign from a second operand). Each operation exists in a single-precision form and a double-precision form, so an opcode selects one of six operations. The unit never rounds, never quiets a NaN and never raises a flag. Every input, signalling NaNs included, is handled as a raw bit pattern.

A single-precision value sits in the low 32 bits of a 64-bit register. Single-precision magnitude and flip fill the upper word of the result with ones, which boxes the value as a NaN. Single-precision sign transfer does not box the result. It copies bits 63:31 from the sign donor and bits 30:0 from the source. A request is presented with `in_vld`, and its result appears with `out_vld` exactly one clock later.

Top module: `fsign_unit`

## Requirements
- R1: Reset sets `out_vld` and `out_res` to zero.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock cycle.
- R3: Opcode 3'd0 (double magnitude): the result is the source with bit 63 cleared and bits 62:0 unchanged.
- R4: Opcode 3'd1 (double flip): the result is the source with only bit 63 inverted.
- R5: Opcode 3'd2 (double sign transfer): the result takes bits 62:0 from the source and bit 63 from the donor.
- R6: Opcode 3'd3 (single magnitude): result bits 30:0 equal source bits 30:0, bit 31 is zero and bits 63:32 are all ones.
- R7: Opcode 3'd4 (single flip): result bit 31 is the inverse of source bit 31, bits 30:0 are unchanged and bits 63:32 are all ones.
- R8: Opcode 3'd5 (single sign transfer): the result takes bits 30:0 from the source and bits 63:31 from the donor, with no boxing applied.
- R9: NaN inputs, signalling NaNs included, are processed as plain bits. The source's upper word has no effect on single magnitude or single flip. The donor has no effect on magnitude or flip.
- R10: While `in_vld` is low, `out_res` holds its previous value. Opcodes 3'd6 and 3'd7 produce a zero result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_vld | input | 1 | Request strobe |
| in_op | input | 3 | Operation select |
| in_src | input | 64 | Source operand |
| in_sgn | input | 64 | Sign-donor operand |
| out_vld | output | 1 | Result strobe, one cycle after the request |
| out_res | output | 64 | Result |

## Verification
Only one register stage lies between the inputs and the outputs, so a wrong selection, a wrong mask or wrong boxing shows as a bad bit in `out_res` on the clock edge after the request. A stuck or skewed valid register shows as `out_vld` disagreeing with the delayed request on that same edge. A hold fault shows on the first idle cycle after a result, when `out_res` changes.

// File: rtl/fsign_pkg.sv
package fsign_pkg;
  parameter int unsigned XLEN = 64;
  parameter int unsigned SLEN = 32;

  typedef enum logic [2:0] {
    OP_ABS_D = 3'd0,
    OP_NEG_D = 3'd1,
    OP_CPY_D = 3'd2,
    OP_ABS_S = 3'd3,
    OP_NEG_S = 3'd4,
    OP_CPY_S = 3'd5
  } fsign_op_e;

  function automatic logic [XLEN-1:0] sgn_abs(input logic [XLEN-1:0] v, input int unsigned sb);
    logic [XLEN-1:0] r;
    r = v;
    r[sb] = 1'b0;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sgn_neg(input logic [XLEN-1:0] v, input int unsigned sb);
    logic [XLEN-1:0] r;
    r = v;
    r[sb] = ~v[sb];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] sgn_cpy(input logic [XLEN-1:0] v, input logic [XLEN-1:0] d,
                                               input int unsigned sb);
    logic [XLEN-1:0] r;
    for (int i = 0; i < XLEN; i++) r[i] = (i >= int'(sb)) ? d[i] : v[i];
    return r;
  endfunction

  function automatic logic [XLEN-1:0] nan_box(input logic [XLEN-1:0] v);
    logic [XLEN-1:0] r;
    r = v;
    r[XLEN-1:SLEN] = '1;
    return r;
  endfunction
endpackage

// File: rtl/fsign_core.sv
module fsign_core
  import fsign_pkg::*;
#(
  parameter int unsigned W = XLEN,
  parameter int unsigned SW = SLEN
) (
  input  logic [2:0]   op,
  input  logic [W-1:0] src,
  input  logic [W-1:0] sgn,
  output logic [W-1:0] res,
  output logic         op_known
);
  localparam int unsigned DSB = W - 1;
  localparam int unsigned SSB = SW - 1;

  always_comb begin
    op_known = 1'b1;
    unique case (op)
      OP_ABS_D: res = sgn_abs(src, DSB);
      OP_NEG_D: res = sgn_neg(src, DSB);
      OP_CPY_D: res = sgn_cpy(src, sgn, DSB);
      OP_ABS_S: res = nan_box(sgn_abs(src, SSB));
      OP_NEG_S: res = nan_box(sgn_neg(src, SSB));
      OP_CPY_S: res = sgn_cpy(src, sgn, SSB);
      default: begin
        res = '0;
        op_known = 1'b0;
      end
    endcase
  end

  always_comb begin
    if (op == OP_ABS_S || op == OP_NEG_S)
      assert_box_R6: assert (&res[W-1:SW]);
    if (op == OP_ABS_D)
      assert_abs_R3: assert (!res[DSB] && res[DSB-1:0] == src[DSB-1:0]);
  end
endmodule

// File: rtl/fsign_unit.sv
module fsign_unit
  import fsign_pkg::*;
#(
  parameter int unsigned W = XLEN
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [2:0]   in_op,
  input  logic [W-1:0] in_src,
  input  logic [W-1:0] in_sgn,
  output logic         out_vld,
  output logic [W-1:0] out_res
);
  logic [W-1:0] core_res;
  logic         core_known;
  logic         res_load;

  fsign_core #(.W(W), .SW(SLEN)) u_core (
    .op(in_op), .src(in_src), .sgn(in_sgn), .res(core_res), .op_known(core_known)
  );

  assign res_load = in_vld;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld <= 1'b0;
      out_res <= '0;
    end else begin
      out_vld <= in_vld;
      if (res_load) out_res <= core_res;
    end
  end

  assert_lat_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_vld |=> out_vld);
  assert_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> !out_vld);
  assert_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !in_vld |=> $stable(out_res));
  assert_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 3'd1) |=> (out_res == {~$past(in_src[W-1]), $past(in_src[W-2:0])}));
  assert_cpy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && in_op == 3'd2) |=> (out_res == {$past(in_sgn[W-1]), $past(in_src[W-2:0])}));
  assert_bad_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_vld && !core_known) |=> (out_res == '0));
endmodule

// File: tb/fsign_unit_test.sv
module fsign_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_vld = 1'b0;
  logic [2:0] in_op = '0;
  logic [63:0] in_src = '0, in_sgn = '0;
  logic out_vld;
  logic [63:0] out_res;
  int n_chk = 0, n_bad = 0;

  always #10 clk = ~clk;

  fsign_unit uut (.clk(clk), .rst_n(rst_n), .in_vld(in_vld), .in_op(in_op),
                  .in_src(in_src), .in_sgn(in_sgn), .out_vld(out_vld), .out_res(out_res));

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic issue(logic [2:0] op, logic [63:0] a, logic [63:0] b, string req, logic [63:0] exp);
    @(negedge clk);
    in_vld = 1'b1; in_op = op; in_src = a; in_sgn = b;
    @(negedge clk);
    in_vld = 1'b0;
    check(req, out_res, exp);
    check({req, " R2 valid"}, {63'd0, out_vld}, 64'd1);
  endtask

  task automatic t_reset;
    check("R1 res", out_res, 64'd0);
    check("R1 vld", {63'd0, out_vld}, 64'd0);
  endtask

  task automatic t_double;
    issue(3'd0, 64'hC00921FB54442D18, 64'h0, "R3", 64'h400921FB54442D18);
    issue(3'd0, 64'h7FF0000000000001, 64'hFFFF, "R3 R9", 64'h7FF0000000000001);
    issue(3'd1, 64'h3FF0000000000000, 64'h0, "R4", 64'hBFF0000000000000);
    issue(3'd1, 64'hFFF8000000000000, 64'h8000000000000000, "R4 R9", 64'h7FF8000000000000);
    issue(3'd2, 64'h3FF0000000000000, 64'h8000000000000000, "R5", 64'hBFF0000000000000);
    issue(3'd2, 64'hBFF0000000000000, 64'h7FFFFFFFFFFFFFFF, "R5 pos", 64'h3FF0000000000000);
  endtask

  task automatic t_single;
    issue(3'd3, 64'h12345678BF800000, 64'h0, "R6", 64'hFFFFFFFF3F800000);
    issue(3'd3, 64'h000000007F800001, 64'h0, "R6 R9", 64'hFFFFFFFF7F800001);
    issue(3'd4, 64'h00000000_3F800000, 64'h0, "R7", 64'hFFFFFFFFBF800000);
    issue(3'd4, 64'hAAAAAAAA_FF800000, 64'h5555, "R7 R9", 64'hFFFFFFFF7F800000);
    issue(3'd5, 64'hFFFFFFFF3F800000, 64'h0123456780000000, "R8", 64'h01234567BF800000);
    issue(3'd5, 64'h00000000BF800000, 64'h0000000000000000, "R8 nobox", 64'h000000003F800000);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    issue(3'd1, 64'h1, 64'h0, "R4 pre", 64'h8000000000000001);
    keep = out_res;
    @(negedge clk); in_op = 3'd0; in_src = 64'hFFFF_FFFF_FFFF_FFFF;
    @(negedge clk);
    check("R10 hold", out_res, keep);
    check("R2 idle", {63'd0, out_vld}, 64'd0);
    issue(3'd6, 64'h1234, 64'h5678, "R10 op6", 64'h0);
    issue(3'd7, 64'h1234, 64'h5678, "R10 op7", 64'h0);
  endtask

  initial begin
    #1;
    t_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_double();
    t_single();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule